// File: doc/BRIEF.md
# Strobe-Sequencing SRAM Interface Controller

This controller sits between a simple synchronous host port and a static RAM that captures its address on the falling edge of an active-low chip strobe. The host presents an address, write data, a write flag and a request. The controller accepts the request only while it is idle. It then produces the whole pin sequence for one memory cycle: address setup with the strobe high, a fixed-width strobe-low window, and a strobe-high recovery window. It finishes with a one-cycle done pulse. For a read, the data the RAM drives is registered in the last strobe-low cycle and is presented on `rd_data`.

Every phase length is a parameter counted in clock cycles. Each must be at least one. For writes, the write strobe falls at least one cycle before the chip strobe falls and rises no earlier than the chip strobe rises, so the RAM never drives the shared bus during a write. After a read, the recovery phase is stretched so that the data driver stays off until the RAM has let go of the bus. An optional burst mode keeps the write strobe low between back-to-back writes, while the chip strobe pulses once per address.

Top module: `strobe_ram_ctrl`

## Requirements
- R1: After reset, `mem_ce_n`=1, `mem_we_n`=1, `mem_doe`=0, `req_ready`=1 and `done`=0.
- R2: A request is taken only in a cycle where `req_ready`=1. A `req_valid` pulse while busy starts no memory cycle and writes nothing. `mem_ce_n` stays low only while `req_ready`=0.
- R3: After the accept edge, `mem_ce_n` stays high for exactly SETUP_CYC cycles with `mem_addr` already holding the request address, then falls.
- R4: `mem_ce_n` stays low for exactly ELOW_CYC cycles. `mem_addr` is stable for the whole low window.
- R5: `done` rises SETUP_CYC+ELOW_CYC+EHIGH_CYC cycles after the accept edge for a write. For a read it rises SETUP_CYC+ELOW_CYC+max(EHIGH_CYC,TURN_CYC) cycles after the accept edge.
- R6: For a write (`req_write`=1), `mem_we_n` is low at least one cycle before `mem_ce_n` falls and is still low in the cycle `mem_ce_n` rises. `mem_doe`=1 with `mem_dout` equal to the write data throughout the low window.
- R7: For a read (`req_write`=0), `mem_we_n`=1 and `mem_doe`=0 while `mem_ce_n` is low. `rd_data` shows the `mem_din` value of the last low cycle when `done` is high.
- R8: `mem_doe` is not asserted until at least TURN_CYC cycles after the cycle in which a read's `mem_ce_n` rose.
- R9: `done` is high for exactly one cycle per accepted request.
- R10: With `burst_mode`=1, `mem_we_n` stays low from one write through the idle cycles to the next write. It goes high in the cycle after a read is accepted, or in the cycle after `burst_mode` drops while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| burst_mode | input | 1 | Hold write strobe low between writes |
| req_valid | input | 1 | Host request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Controller idle, request may be taken |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W | Registered read data |
| mem_ce_n | output | 1 | RAM chip strobe, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_addr | output | ADDR_W | RAM address |
| mem_dout | output | DATA_W | Data toward the RAM |
| mem_doe | output | 1 | Drive enable for `mem_dout` |
| mem_din | input | DATA_W | Data from the RAM |

## Verification
The hardest situations to reach are the bus hand-over from a read to an immediately following write, and a read that arrives while burst mode holds the write strobe low. The stimulus table places reads directly in front of writes, so the turnaround gap is measured at its minimum. A directed sequence enables burst mode, issues several writes and then a read, and watches the strobes between operations. A further directed case pulses a request mid-operation, then reads back the target location to show that it was never written.

// File: rtl/srs_pkg.sv
package srs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_RECOV  = 2'd3
    } srs_state_e;

    function automatic int srs_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/srs_phase_timer.sv
module srs_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             last
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = len;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign last = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/srs_read_capture.sv
module srs_read_capture #(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] data_d, data_q;

    always_comb begin
        data_d = capture ? din : data_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign dout = data_q;
endmodule

// File: rtl/strobe_ram_ctrl.sv
module strobe_ram_ctrl
    import srs_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 4,
    parameter int SETUP_CYC = 2,
    parameter int ELOW_CYC  = 3,
    parameter int EHIGH_CYC = 2,
    parameter int TURN_CYC  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_mode,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dout,
    output logic              mem_doe,
    input  logic [DATA_W-1:0] mem_din
);
    localparam int RD_REC_CYC = srs_max(EHIGH_CYC, TURN_CYC);
    localparam int MAX_CYC    = srs_max(srs_max(SETUP_CYC, ELOW_CYC), RD_REC_CYC);
    localparam int CNT_W      = $clog2(MAX_CYC + 1) + 1;

    typedef struct packed {
        srs_state_e        state;
        logic              ce_n;
        logic              we_n;
        logic              doe;
        logic              wr;
        logic              done;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_len;
    logic             tmr_last;
    logic             cap_en;

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_len  = '0;
        cap_en   = 1'b0;
        case (ctl_q.state)
            ST_IDLE: begin
                ctl_d.doe  = 1'b0;
                ctl_d.we_n = !(burst_mode && ctl_q.wr);
                if (req_valid) begin
                    ctl_d.state = ST_SETUP;
                    ctl_d.wr    = req_write;
                    ctl_d.addr  = req_addr;
                    ctl_d.wdata = req_wdata;
                    ctl_d.we_n  = !req_write;
                    ctl_d.doe   = req_write;
                    tmr_load    = 1'b1;
                    tmr_len     = CNT_W'(SETUP_CYC);
                end
            end
            ST_SETUP: begin
                if (tmr_last) begin
                    ctl_d.state = ST_ACTIVE;
                    ctl_d.ce_n  = 1'b0;
                    tmr_load    = 1'b1;
                    tmr_len     = CNT_W'(ELOW_CYC);
                end
            end
            ST_ACTIVE: begin
                if (tmr_last) begin
                    ctl_d.state = ST_RECOV;
                    ctl_d.ce_n  = 1'b1;
                    cap_en      = !ctl_q.wr;
                    tmr_load    = 1'b1;
                    tmr_len     = ctl_q.wr ? CNT_W'(EHIGH_CYC) : CNT_W'(RD_REC_CYC);
                end
            end
            default: begin
                if (tmr_last) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.done  = 1'b1;
                    ctl_d.doe   = 1'b0;
                    ctl_d.we_n  = !(burst_mode && ctl_q.wr);
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
            ctl_q.ce_n  <= 1'b1;
            ctl_q.we_n  <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    srs_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .len   (tmr_len),
        .last  (tmr_last)
    );

    srs_read_capture #(.DATA_W(DATA_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cap_en),
        .din     (mem_din),
        .dout    (rd_data)
    );

    assign req_ready = (ctl_q.state == ST_IDLE);
    assign done      = ctl_q.done;
    assign mem_ce_n  = ctl_q.ce_n;
    assign mem_we_n  = ctl_q.we_n;
    assign mem_addr  = ctl_q.addr;
    assign mem_dout  = ctl_q.wdata;
    assign mem_doe   = ctl_q.doe;
endmodule

// File: rtl/srs_ctrl_chk.sv
module srs_ctrl_chk #(
    parameter int ADDR_W   = 10,
    parameter int TURN_CYC = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              done,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_doe,
    input logic [ADDR_W-1:0] mem_addr
);
    localparam int TW = $clog2(TURN_CYC + 2) + 1;

    logic          prev_ce_q;
    logic [TW-1:0] turn_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_ce_q <= 1'b1;
            turn_q    <= TW'(TURN_CYC);
        end else begin
            prev_ce_q <= mem_ce_n;
            if (mem_ce_n && !prev_ce_q && mem_we_n) turn_q <= TW'(1);
            else if (turn_q < TW'(TURN_CYC))        turn_q <= turn_q + 1'b1;
        end
    end

    // R2
    busy_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !req_ready);
    // R4
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
    // R6
    wr_we_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && mem_doe) |-> !mem_we_n);
    // R6
    we_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_ce_n) && mem_doe) |-> $past(!mem_we_n));
    // R6
    we_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_ce_n) && $past(!mem_we_n)) |-> !mem_we_n);
    // R7
    rd_we_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !mem_doe) |-> mem_we_n);
    // R8
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_doe |-> (turn_q >= TW'(TURN_CYC)));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind strobe_ram_ctrl srs_ctrl_chk #(.ADDR_W(ADDR_W), .TURN_CYC(TURN_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .done      (done),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_doe   (mem_doe),
    .mem_addr  (mem_addr)
);

// File: tb/strobe_ram_ctrl_tb.sv
`timescale 1ns/1ps
module strobe_ram_ctrl_tb;
    localparam int AW = 10, DW = 4;
    localparam int SU = 2, EL = 3, EH = 2, TN = 4;
    localparam int RDREC = (EH > TN) ? EH : TN;
    localparam int NV = 10;
    // vector: {write, addr, wdata, expected read data}
    localparam logic [18:0] VEC [NV] = '{
        {1'b1, 10'h000, 4'hA, 4'h0},
        {1'b1, 10'h3FF, 4'h5, 4'h0},
        {1'b1, 10'h12C, 4'h3, 4'h0},
        {1'b1, 10'h0F0, 4'hF, 4'h0},
        {1'b0, 10'h000, 4'h0, 4'hA},
        {1'b0, 10'h3FF, 4'h0, 4'h5},
        {1'b1, 10'h12C, 4'hC, 4'h0},
        {1'b0, 10'h12C, 4'h0, 4'hC},
        {1'b0, 10'h0F0, 4'h0, 4'hF},
        {1'b0, 10'h200, 4'h0, 4'h0}
    };

    logic clk = 0, rst_n = 0, burst_mode = 0, req_valid = 0, req_write = 0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, done, mem_ce_n, mem_we_n, mem_doe;
    logic [DW-1:0] rd_data, mem_dout, mem_din;
    logic [AW-1:0] mem_addr;
    int errors = 0, checks = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    strobe_ram_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(SU), .ELOW_CYC(EL),
                      .EHIGH_CYC(EH), .TURN_CYC(TN)) u_dut (
        .clk(clk), .rst_n(rst_n), .burst_mode(burst_mode), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .rd_data(rd_data), .mem_ce_n(mem_ce_n),
        .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
        .mem_doe(mem_doe), .mem_din(mem_din));

    // RAM model: address latched on strobe fall, write on strobe rise
    logic [DW-1:0] ram [1024];
    logic [AW-1:0] lat_addr = '0;
    always @(negedge mem_ce_n) lat_addr = mem_addr;
    always @(posedge mem_ce_n or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) ram[i] = '0;
        end else if (!mem_we_n) begin
            ram[lat_addr] = mem_dout;
        end
    end
    assign mem_din = (!mem_ce_n && mem_we_n) ? ram[lat_addr] : '0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // pin monitors
    logic prev_ce = 1, prev_we = 1, prev_doe = 0, low_bad = 0, addr_moved = 0;
    int low_cnt = 0, su_cnt = 0, gap = 1000;
    logic [AW-1:0] low_addr = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_ce_n) begin
                if (prev_ce) begin
                    chk(su_cnt == SU, "R3 setup cycles", su_cnt, SU);
                    if (mem_doe) chk(prev_we == 1'b0, "R6 W leads E", prev_we, 0);
                    low_cnt = 0; low_bad = 0; addr_moved = 0; low_addr = mem_addr;
                end
                low_cnt++;
                if (mem_addr != low_addr) addr_moved = 1;
                if (mem_doe && mem_we_n) low_bad = 1;
                if (!mem_doe && !mem_we_n) low_bad = 1;
                su_cnt = 0;
            end else begin
                if (!prev_ce) begin
                    chk(low_cnt == EL, "R4 E-low width", low_cnt, EL);
                    chk(!addr_moved, "R4 addr stable", addr_moved, 0);
                    chk(!low_bad, "R6/R7 W level during E low", low_bad, 0);
                    if (!prev_doe) chk(mem_we_n == 1'b1, "R7 read W", mem_we_n, 1);
                    else chk(mem_we_n == 1'b0, "R6 W trails E", mem_we_n, 0);
                    if (mem_we_n && !prev_doe) gap = 0;
                end
                if (req_ready) su_cnt = 0; else su_cnt++;
            end
            if (mem_doe && !prev_doe) chk(gap >= TN, "R8 turnaround", gap, TN);
            gap++;
            prev_ce = mem_ce_n; prev_we = mem_we_n; prev_doe = mem_doe;
        end
    end

    task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit chk_rd, input logic [DW-1:0] exp);
        int n, explat;
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 ready before request", req_ready, 1);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        n = 0;
        do begin
            @(negedge clk);
            req_valid = 0;
            n++;
        end while (!done && n < 100);
        explat = 1 + SU + EL + (wr ? EH : RDREC);
        chk(n == explat, wr ? "R5 write latency" : "R5 read latency", n, explat);
        if (chk_rd) chk(rd_data == exp, "R7 read data", rd_data, exp);
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", done, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(mem_ce_n == 1 && mem_we_n == 1 && mem_doe == 0, "R1 strobes at reset",
            {mem_ce_n, mem_we_n, mem_doe}, 3'b110);
        chk(req_ready == 1 && done == 0, "R1 ready/done at reset", {req_ready, done}, 2'b10);
        rst_n = 1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            do_op(VEC[i][18], VEC[i][17:8], VEC[i][7:4], !VEC[i][18], VEC[i][3:0]);
        end

        // R2: request pulse while busy is ignored
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 10'h055; req_wdata = 4'h9;
        @(negedge clk);
        req_valid = 0;
        repeat (3) @(negedge clk);
        chk(req_ready == 0, "R2 busy", req_ready, 0);
        req_valid = 1; req_write = 1; req_addr = 10'h155; req_wdata = 4'h7;
        @(negedge clk);
        req_valid = 0;
        while (!done) @(negedge clk);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (k == 9) chk(mem_ce_n == 1'b1, "R2 no extra cycle", mem_ce_n, 1);
        end
        do_op(0, 10'h155, 4'h0, 1, 4'h0);
        do_op(0, 10'h055, 4'h0, 1, 4'h9);

        // R10 burst writes hold W low
        burst_mode = 1;
        do_op(1, 10'h011, 4'h1, 0, 4'h0);
        chk(mem_we_n == 1'b0, "R10 W low between writes", mem_we_n, 0);
        do_op(1, 10'h012, 4'h2, 0, 4'h0);
        chk(mem_we_n == 1'b0, "R10 W low between writes", mem_we_n, 0);
        do_op(1, 10'h013, 4'h3, 0, 4'h0);
        do_op(0, 10'h012, 4'h0, 1, 4'h2);
        chk(mem_we_n == 1'b1, "R10 W high after read", mem_we_n, 1);
        do_op(1, 10'h014, 4'h4, 0, 4'h0);
        chk(mem_we_n == 1'b0, "R10 W held after write", mem_we_n, 0);
        burst_mode = 0;
        repeat (2) @(negedge clk);
        chk(mem_we_n == 1'b1, "R10 W released when burst off", mem_we_n, 1);
        do_op(0, 10'h013, 4'h0, 1, 4'h3);
        do_op(0, 10'h014, 4'h0, 1, 4'h4);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule